// File: doc/BRIEF.md
# Staged Multicast Address Table Port

This block keeps a small table of 48-bit Ethernet multicast addresses that the host can reach only indirectly. Two staging words sit between the host and the table. The low staging word holds address bits 31:0. The high staging word holds address bits 47:32, an entry selector and a direction bit. A host write to the high word with the direction bit clear commits one whole entry. With the direction bit set, the same write fetches one whole entry back into both staging words.

The host never addresses the staging words directly. It sees three direct registers: a data register, a command register and a status register. To write a staging word, the host first places the value in the data register. It then writes the command register with the write flag set and the code of the staging word. To read a staging word, the host writes the command register with the write flag clear. After completion the value appears in the data register. Every command drops the ready flag. Ready comes back a fixed number of clocks later, and a one-cycle completion pulse fires at that moment.

Addresses keep the first byte on the wire in the lowest byte lane. For example, the address AA-BB-CC-DD-EE-FF is held as 0xFFEEDDCCBBAA.

Top module: `mcast_tbl_port`

## Requirements
- R1: After reset the following values hold: ready is 1, the completion pulse is 0, the data register reads 0 and the command register reads 0. Every table entry, fetched and read back, reads as zero.
- R2: Direct register selects are 0 for data, 1 for command and 2 for status (bit 0 = ready). The command word has the write flag at bit 15 and the staging-word code in bits 11:0. A command write drops ready on the next cycle. Ready returns exactly LATENCY clocks (default 3) after the edge that took the command. The command register reads back the last command's flag and code.
- R3: The completion pulse is high for exactly one cycle, in the same cycle that ready rises.
- R4: Code 0x388 selects the low staging word (address bits 31:0). A write through it stages the value. A read through it returns the staged value in the data register.
- R5: Code 0x38C selects the high staging word. In that word, bits 15:0 are address bits 47:32, bits 17:16 select the entry and bit 23 is the direction (0 = write, 1 = read). Writing it with bit 23 clear commits {bits 15:0, low staging word} to the selected entry. Writing it with bit 23 set loads that entry into both staging words.
- R6: Bits 31:24 and 22:18 of the high staging word are discarded on write and always read back as 0.
- R7: A command carrying any other code still completes with ready and the pulse. It changes neither staging word, the table nor the data register.
- R8: The four entries are independent. A byte-ordered address such as 0xFFEEDDCCBBAA comes back unchanged from its own entry.
- R9: A command issued while another is pending abandons the pending one. Ready then returns LATENCY clocks after the new command.
- R10: A command uses the data register value present when it is issued. A data register write after issue does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Direct register write strobe |
| reg_sel | input | 2 | Direct register select: 0 data, 1 command, 2 status |
| reg_wdata | input | 32 | Direct register write value |
| reg_rdata | output | 32 | Direct register read value for reg_sel |
| ready | output | 1 | Last command has completed |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
If the latency counter is corrupted, ready comes back early, late or not at all. The bench times this against LATENCY on the first command after the fault. A wrong staging word or table entry stays hidden until that entry is fetched and both words are read back through the data register. That takes a fetch plus two reads, roughly three command latencies after the fetch. For this reason every entry is written with a distinct pattern and read back. A wrongly kept reserved bit or a stale command capture shows in the data register on the first word read after the faulty operation.

// File: rtl/mcast_pkg.sv
package mcast_pkg;
   localparam int unsigned MAC_W     = 48;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned CODE_W    = 12;
   localparam int unsigned WFLAG_BIT = 15;
   localparam int unsigned SEL_LSB   = 16;
   localparam int unsigned DIR_BIT   = 23;

   localparam logic [1:0] RSEL_DATA = 2'd0;
   localparam logic [1:0] RSEL_CMD  = 2'd1;
   localparam logic [1:0] RSEL_STAT = 2'd2;

   typedef struct packed {
      logic              wflag;
      logic [CODE_W-1:0] code;
      logic [WORD_W-1:0] data;
   } ind_cmd_t;
endpackage

// File: rtl/mcast_host_regs.sv
module mcast_host_regs
   import mcast_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [WORD_W-1:0] reg_wdata,
   input  logic              ready,
   input  logic              data_load,
   input  logic [WORD_W-1:0] data_val,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              issue,
   output ind_cmd_t          cmd
);
   logic [WORD_W-1:0] data_q;
   logic              wflag_q;
   logic [CODE_W-1:0] code_q;
   logic              unused_wbits;

   assign unused_wbits = ^{reg_wdata[WORD_W-1:WFLAG_BIT+1], reg_wdata[WFLAG_BIT-1:CODE_W]};
   assign issue        = reg_wr && (reg_sel == RSEL_CMD);
   assign cmd          = '{wflag: reg_wdata[WFLAG_BIT], code: reg_wdata[CODE_W-1:0], data: data_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         wflag_q <= 1'b0;
         code_q  <= '0;
      end else begin
         if (reg_wr && reg_sel == RSEL_DATA)
            data_q <= reg_wdata;
         else if (data_load)
            data_q <= data_val;
         if (issue) begin
            wflag_q <= reg_wdata[WFLAG_BIT];
            code_q  <= reg_wdata[CODE_W-1:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_sel)
         RSEL_DATA: reg_rdata = data_q;
         RSEL_CMD: begin
            reg_rdata[WFLAG_BIT]    = wflag_q;
            reg_rdata[CODE_W-1:0]   = code_q;
         end
         RSEL_STAT: reg_rdata[0] = ready;
         default:   reg_rdata = '0;
      endcase
   end

   // R2
   cmd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> (code_q == $past(reg_wdata[CODE_W-1:0])) && (wflag_q == $past(reg_wdata[WFLAG_BIT])));
endmodule

// File: rtl/mcast_seq.sv
module mcast_seq
   import mcast_pkg::*;
#(
   parameter int unsigned LATENCY = 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     issue,
   input  ind_cmd_t cmd_in,
   output logic     ready,
   output logic     done_irq,
   output logic     exec,
   output ind_cmd_t cmd_q
);
   localparam int unsigned CNT_W = (LATENCY > 2) ? $clog2(LATENCY) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

   logic             busy;
   logic [CNT_W-1:0] cnt;

   generate
      if (LATENCY < 2 || LATENCY > 4) begin : g_bad_latency
         $error("mcast_seq: LATENCY must be 2 to 4");
      end
   endgenerate

   assign exec = busy && (cnt == '0) && !issue;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         cmd_q    <= '0;
         ready    <= 1'b1;
         done_irq <= 1'b0;
      end else if (issue) begin
         busy     <= 1'b1;
         cnt      <= CNT_LOAD;
         cmd_q    <= cmd_in;
         ready    <= 1'b0;
         done_irq <= 1'b0;
      end else if (exec) begin
         busy     <= 1'b0;
         ready    <= 1'b1;
         done_irq <= 1'b1;
      end else begin
         if (busy) cnt <= cnt - 1'b1;
         done_irq <= 1'b0;
      end
   end

   // R2
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> !ready);
   // R3
   irq_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> ready);
   // R3
   rise_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> done_irq);
   // R3
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> !done_irq);
   // R9
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt <= CNT_LOAD));
endmodule

// File: rtl/mcast_store.sv
module mcast_store
   import mcast_pkg::*;
#(
   parameter int unsigned        ENTRIES = 4,
   parameter logic [CODE_W-1:0]  LO_CODE = 12'h388,
   parameter logic [CODE_W-1:0]  HI_CODE = 12'h38C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec,
   input  ind_cmd_t          cmd,
   output logic              data_load,
   output logic [WORD_W-1:0] data_val
);
   localparam int unsigned SEL_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int unsigned HI_W  = MAC_W - WORD_W;

   logic [WORD_W-1:0]             lo_q;
   logic [HI_W-1:0]               hi_q;
   logic [SEL_W-1:0]              sel_q;
   logic                          dir_q;
   logic [ENTRIES-1:0][MAC_W-1:0] tbl;
   logic                          is_lo, is_hi, is_commit, is_fetch;
   logic [SEL_W-1:0]              new_sel;
   logic                          unused_cbits;

   generate
      if (ENTRIES != 2 && ENTRIES != 4) begin : g_bad_entries
         $error("mcast_store: ENTRIES must be 2 or 4");
      end
      if (LO_CODE == HI_CODE) begin : g_bad_codes
         $error("mcast_store: staging word codes must differ");
      end
   endgenerate

   assign unused_cbits = ^{cmd.data[WORD_W-1:DIR_BIT+1], cmd.data[DIR_BIT-1:SEL_LSB+SEL_W]};
   assign is_lo     = (cmd.code == LO_CODE);
   assign is_hi     = (cmd.code == HI_CODE);
   assign new_sel   = cmd.data[SEL_LSB +: SEL_W];
   assign is_commit = exec && cmd.wflag && is_hi && !cmd.data[DIR_BIT];
   assign is_fetch  = exec && cmd.wflag && is_hi &&  cmd.data[DIR_BIT];

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
         logic [MAC_W-1:0] ent_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ent_q <= '0;
            else if (is_commit && new_sel == SEL_W'(e))
               ent_q <= {cmd.data[HI_W-1:0], lo_q};
         end
         assign tbl[e] = ent_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         sel_q <= '0;
         dir_q <= 1'b0;
      end else if (exec && cmd.wflag) begin
         if (is_lo) begin
            lo_q <= cmd.data;
         end else if (is_hi) begin
            sel_q <= new_sel;
            dir_q <= cmd.data[DIR_BIT];
            if (cmd.data[DIR_BIT]) begin
               lo_q <= tbl[new_sel][WORD_W-1:0];
               hi_q <= tbl[new_sel][MAC_W-1:WORD_W];
            end else begin
               hi_q <= cmd.data[HI_W-1:0];
            end
         end
      end
   end

   assign data_load = exec && !cmd.wflag && (is_lo || is_hi);

   always_comb begin
      data_val = '0;
      if (is_lo) begin
         data_val = lo_q;
      end else begin
         data_val[HI_W-1:0]             = hi_q;
         data_val[SEL_LSB +: SEL_W]     = sel_q;
         data_val[DIR_BIT]              = dir_q;
      end
   end

   // R7
   unknown_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && !is_lo && !is_hi) |=> $stable(lo_q) && $stable(hi_q) && $stable(tbl));
   // R5
   fetch_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_fetch |=> (hi_q == $past(tbl[new_sel][MAC_W-1:WORD_W])) && (sel_q == $past(new_sel)));
endmodule

// File: rtl/mcast_tbl_port.sv
module mcast_tbl_port
   import mcast_pkg::*;
#(
   parameter int unsigned       ENTRIES = 4,
   parameter int unsigned       LATENCY = 3,
   parameter logic [11:0]       LO_CODE = 12'h388,
   parameter logic [11:0]       HI_CODE = 12'h38C
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [1:0]  reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        ready,
   output logic        done_irq
);
   logic              issue, exec, data_load;
   logic [WORD_W-1:0] data_val;
   ind_cmd_t          cmd_new, cmd_run;

   mcast_host_regs i_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .ready(ready), .data_load(data_load),
      .data_val(data_val), .reg_rdata(reg_rdata), .issue(issue), .cmd(cmd_new)
   );

   mcast_seq #(.LATENCY(LATENCY)) i_seq (
      .clk(clk), .rst_n(rst_n), .issue(issue), .cmd_in(cmd_new),
      .ready(ready), .done_irq(done_irq), .exec(exec), .cmd_q(cmd_run)
   );

   mcast_store #(.ENTRIES(ENTRIES), .LO_CODE(LO_CODE), .HI_CODE(HI_CODE)) i_store (
      .clk(clk), .rst_n(rst_n), .exec(exec), .cmd(cmd_run),
      .data_load(data_load), .data_val(data_val)
   );

   // R6
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_load |=> (reg_sel != RSEL_DATA) || (reg_rdata[31:24] == '0 && reg_rdata[22:18] == '0)
                    || (cmd_run.code == LO_CODE));
endmodule

// File: tb/test_mcast_tbl_port.sv
module test_mcast_tbl_port;
   localparam int LAT = 3;
   localparam logic [11:0] LO = 12'h388;
   localparam logic [11:0] HI = 12'h38C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ready, done_irq;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #10ns clk = ~clk;

   mcast_tbl_port #(.LATENCY(LAT)) i_mcast_tbl_port (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ready(ready), .done_irq(done_irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [31:0] v);
      reg_sel = s;
      #1ns v = reg_rdata;
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!ready && n < 40) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic cmd(input bit wf, input logic [11:0] code, output int n);
      wr(2'd1, {16'h0, wf, 3'b0, code});
      wait_ready(n);
   endtask

   task automatic iwrite(input logic [11:0] code, input logic [31:0] d);
      int n;
      wr(2'd0, d);
      cmd(1'b1, code, n);
   endtask

   task automatic iread(input logic [11:0] code, output logic [31:0] v);
      int n;
      cmd(1'b0, code, n);
      rd(2'd0, v);
   endtask

   task automatic put_entry(input int e, input logic [47:0] a);
      iwrite(LO, a[31:0]);
      iwrite(HI, {8'h0, 1'b0, 5'b0, 2'(e), a[47:32]});
   endtask

   task automatic get_entry(input int e, output logic [47:0] a, output logic [31:0] hiw);
      logic [31:0] lo;
      iwrite(HI, {8'h0, 1'b1, 5'b0, 2'(e), 16'h0});
      iread(LO, lo);
      iread(HI, hiw);
      a = {hiw[15:0], lo};
   endtask

   task automatic t_reset;
      logic [31:0] v;
      logic [47:0] a;
      chk(ready === 1'b1, "R1 ready after reset", ready, 1);
      chk(done_irq === 1'b0, "R1 pulse after reset", done_irq, 0);
      rd(2'd0, v); chk(v === 32'h0, "R1 data reg", v, 0);
      rd(2'd1, v); chk(v === 32'h0, "R1 command reg", v, 0);
      rd(2'd2, v); chk(v === 32'h1, "R1 status reg", v, 1);
      for (int e = 0; e < 4; e++) begin
         get_entry(e, a, v);
         chk(a === 48'h0, "R1 entry zero", a, 0);
      end
   endtask

   task automatic t_latency;
      int n;
      logic [31:0] v;
      wr(2'd1, {16'h0, 1'b1, 3'b0, 12'h123});
      chk(ready === 1'b0, "R2 ready drops", ready, 0);
      rd(2'd2, v); chk(v === 32'h0, "R2 status reads busy", v, 0);
      wait_ready(n);
      chk(n == LAT, "R2 latency", n, LAT);
      chk(done_irq === 1'b1, "R3 pulse with ready", done_irq, 1);
      @(negedge clk);
      chk(done_irq === 1'b0, "R3 pulse one cycle", done_irq, 0);
      rd(2'd1, v); chk(v === 32'h0000_8123, "R2 command readback", v, 32'h8123);
   endtask

   task automatic t_stage;
      logic [31:0] v;
      iwrite(LO, 32'hDEAD_BEEF);
      iread(LO, v);
      chk(v === 32'hDEAD_BEEF, "R4 low word readback", v, 32'hDEADBEEF);
   endtask

   task automatic t_entries;
      logic [47:0] a;
      logic [31:0] h;
      logic [47:0] pat [4];
      pat[0] = 48'hFFEE_DDCC_BBAA;
      pat[1] = 48'h0123_4567_89AB;
      pat[2] = 48'h5A5A_A5A5_0F0F;
      pat[3] = 48'h8001_0000_0001;
      for (int e = 0; e < 4; e++) put_entry(e, pat[e]);
      for (int e = 3; e >= 0; e--) begin
         get_entry(e, a, h);
         chk(a === pat[e], "R8 entry readback", a, pat[e]);
         chk(h === {8'h0, 1'b1, 5'b0, 2'(e), pat[e][47:32]}, "R5 high word after fetch",
             h, {8'h0, 1'b1, 5'b0, 2'(e), pat[e][47:32]});
      end
   endtask

   task automatic t_reserved;
      logic [31:0] v;
      logic [47:0] a;
      iwrite(LO, 32'h1111_2222);
      iwrite(HI, 32'hFF7F_FFFF);
      iread(HI, v);
      chk(v === 32'h0003_FFFF, "R6 reserved bits zero", v, 32'h0003FFFF);
      get_entry(3, a, v);
      chk(a === 48'hFFFF_1111_2222, "R5 commit entry 3", a, 48'hFFFF11112222);
   endtask

   task automatic t_unknown;
      logic [31:0] v;
      int n;
      iwrite(LO, 32'hCAFE_0001);
      wr(2'd0, 32'h7777_7777);
      cmd(1'b1, 12'h390, n);
      chk(n == LAT, "R7 unknown code completes", n, LAT);
      rd(2'd0, v); chk(v === 32'h7777_7777, "R7 data reg kept after unknown write", v, 32'h77777777);
      cmd(1'b0, 12'h384, n);
      rd(2'd0, v); chk(v === 32'h7777_7777, "R7 data reg kept after unknown read", v, 32'h77777777);
      iread(LO, v);
      chk(v === 32'hCAFE_0001, "R7 low word unchanged", v, 32'hCAFE0001);
   endtask

   task automatic t_restart;
      logic [31:0] v;
      int n;
      iwrite(LO, 32'h0000_AAAA);
      wr(2'd0, 32'h0000_BBBB);
      wr(2'd1, {16'h0, 1'b1, 3'b0, LO});
      wr(2'd1, {16'h0, 1'b1, 3'b0, 12'h3FF});
      wait_ready(n);
      chk(n == LAT, "R9 latency from new command", n, LAT);
      iread(LO, v);
      chk(v === 32'h0000_AAAA, "R9 abandoned command", v, 32'hAAAA);
   endtask

   task automatic t_capture;
      logic [31:0] v;
      int n;
      wr(2'd0, 32'h1357_9BDF);
      wr(2'd1, {16'h0, 1'b1, 3'b0, LO});
      wr(2'd0, 32'h2468_ACE0);
      wait_ready(n);
      iread(LO, v);
      chk(v === 32'h1357_9BDF, "R10 value captured at issue", v, 32'h13579BDF);
   endtask

   initial begin
      #(20ns * 100000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_latency;
      t_stage;
      t_entries;
      t_reserved;
      t_unknown;
      t_restart;
      t_capture;
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule